// File: doc/BRIEF.md
# Rising-Edge Pullup Timing Controller

This block decides when a low-impedance pullup transistor should help a single-wire open-drain bus rise back to its idle level. It watches a pulldown-active indication, which covers both the master and any slave driving the line low. When that pulldown ends, it waits for a digital flag from the line comparator saying the rising voltage has crossed a level between the low and high input thresholds. It then drives a pullup-enable output for a programmable number of clock cycles. After that, the line rises on the resistive pullup alone.

Two kinds of edge must not be accelerated: the edge that ends a presence pulse, and the recovery after a bus short. Qualifier inputs mark these edges, and the controller leaves them to the resistor. The surrounding logic may also request a strong pullup. In that case the output stays on after the timed phase until a release input arrives. The controller then emits a one-cycle end pulse, which the configuration logic uses to clear its strong-pullup bit. A new pulldown at any time cancels the pullup and restarts the sequence.

Top module: `rise_boost_ctrl`

## Requirements
- R1: While the active-pullup enable `apu_en` is low, at the end of a pulldown or while waiting for the threshold, `pu_on` does not assert and the edge completes on the resistive pullup.
- R2: A sequence arms only when `pd_active` is sampled low after being sampled high. A `thr_hit` seen while the pulldown is still active is ignored.
- R3: In the rising phase, the clock edge that first samples `thr_hit` high sets `pu_on` high through a single register.
- R4: `pu_on` stays high for exactly `ON_CYCLES` clock cycles. If `spu_req` is low at expiry, it then falls.
- R5: If `presence_edge` or `short_edge` is high in the cycle where the end of the pulldown is sampled, that edge is skipped and `pu_on` stays low even when `thr_hit` rises.
- R6: If `spu_req` is high when the on-time expires, `pu_on` remains high beyond `ON_CYCLES` until it is released.
- R7: During the extended phase, a sampled `spu_release` drops `pu_on` at that clock edge and raises `spu_done` for exactly one cycle.
- R8: A sampled `pd_active` during the timed or extended phase drops `pu_on` at that edge without any `spu_done`. The controller then waits for the new pulldown to end.
- R9: While the synchronous reset `rst` is high, `pu_on` and `spu_done` are low and the controller is idle.
- R10: `spu_release` outside the extended phase has no effect, and `spu_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_active | input | 1 | A pulldown (master or slave) holds the line low |
| thr_hit | input | 1 | Comparator: line passed the mid-level threshold |
| apu_en | input | 1 | Active pullup enable |
| spu_req | input | 1 | Strong pullup requested |
| presence_edge | input | 1 | Ending pulldown was a presence pulse |
| short_edge | input | 1 | Ending pulldown was a short recovery |
| spu_release | input | 1 | Ends the extended strong-pullup phase |
| pu_on | output | 1 | Pullup transistor enable (registered) |
| spu_done | output | 1 | One-cycle pulse at the end of a strong pullup |

## Verification
The bench builds the controller with `ON_CYCLES` set to 3. This makes the on-time expire within a handful of vectors, so the exact pulse length, the handover into the strong-pullup phase, and a pulldown cutting into either phase all fit in one short table. At this length, an off-by-one in the timer changes the expected output on a specific vector.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_RISE  = 3'd2,
    ST_BOOST = 3'd3,
    ST_HOLD  = 3'd4
  } rbc_state_e;
endpackage

// File: rtl/rbc_ontimer.sv
module rbc_ontimer #(
  parameter int ON_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  output logic expire
);
  localparam int CNT_W = (ON_CYCLES > 1) ? $clog2(ON_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(ON_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (clear || expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rbc_seq.sv
module rbc_seq
  import rbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pd_active,
  input  logic thr_hit,
  input  logic apu_en,
  input  logic spu_req,
  input  logic skip_edge,
  input  logic spu_release,
  input  logic expire,
  output logic tmr_start,
  output logic tmr_clear,
  output logic pu_q,
  output logic done_q
);
  rbc_state_e st_q, st_d;
  logic       done_d;

  always_comb begin
    st_d      = st_q;
    tmr_start = 1'b0;
    tmr_clear = 1'b0;
    done_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pd_active) st_d = ST_LOW;
      ST_LOW: begin
        if (!pd_active) st_d = (skip_edge || !apu_en) ? ST_IDLE : ST_RISE;
      end
      ST_RISE: begin
        if (pd_active)    st_d = ST_LOW;
        else if (!apu_en) st_d = ST_IDLE;
        else if (thr_hit) begin
          st_d      = ST_BOOST;
          tmr_start = 1'b1;
        end
      end
      ST_BOOST: begin
        if (pd_active) begin
          st_d      = ST_LOW;
          tmr_clear = 1'b1;
        end else if (expire) begin
          st_d = spu_req ? ST_HOLD : ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (pd_active) st_d = ST_LOW;
        else if (spu_release) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pu_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pu_q   <= (st_d == ST_BOOST) || (st_d == ST_HOLD);
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/rise_boost_ctrl.sv
module rise_boost_ctrl #(
  parameter int ON_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_active,
  input  logic thr_hit,
  input  logic apu_en,
  input  logic spu_req,
  input  logic presence_edge,
  input  logic short_edge,
  input  logic spu_release,
  output logic pu_on,
  output logic spu_done
);
  logic tmr_start, tmr_clear, expire;
  logic skip_edge;

  assign skip_edge = presence_edge | short_edge;

  rbc_ontimer #(.ON_CYCLES(ON_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .clear  (tmr_clear),
    .expire (expire)
  );

  rbc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .pd_active   (pd_active),
    .thr_hit     (thr_hit),
    .apu_en      (apu_en),
    .spu_req     (spu_req),
    .skip_edge   (skip_edge),
    .spu_release (spu_release),
    .expire      (expire),
    .tmr_start   (tmr_start),
    .tmr_clear   (tmr_clear),
    .pu_q        (pu_on),
    .done_q      (spu_done)
  );
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker (
  input logic clk,
  input logic rst,
  input logic pd_active,
  input logic thr_hit,
  input logic apu_en,
  input logic spu_release,
  input logic pu_on,
  input logic spu_done
);
  assert_apu_gate_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(pu_on) |-> $past(apu_en));

  assert_rise_on_threshold_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pu_on) |-> ($past(thr_hit) && !$past(pd_active)));

  assert_pulldown_cancels_R8: assert property (@(posedge clk) disable iff (rst)
    pd_active |=> (!pu_on && !spu_done));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    spu_done |=> !spu_done);

  assert_done_needs_release_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(spu_done) |-> ($past(spu_release) && $past(pu_on)));

  assert_done_drops_pullup_R7: assert property (@(posedge clk) disable iff (rst)
    spu_done |-> !pu_on);
endmodule

bind rise_boost_ctrl rbc_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .pd_active   (pd_active),
  .thr_hit     (thr_hit),
  .apu_en      (apu_en),
  .spu_release (spu_release),
  .pu_on       (pu_on),
  .spu_done    (spu_done)
);

// File: tb/rise_boost_ctrl_tb.sv
module rise_boost_ctrl_tb;
  localparam int ON_T = 3;
  localparam int NV   = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_active = 1'b0, thr_hit = 1'b0, apu_en = 1'b0, spu_req = 1'b0;
  logic presence_edge = 1'b0, short_edge = 1'b0, spu_release = 1'b0;
  logic pu_on, spu_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  rise_boost_ctrl #(.ON_CYCLES(ON_T)) u_dut (
    .clk(clk), .rst(rst), .pd_active(pd_active), .thr_hit(thr_hit),
    .apu_en(apu_en), .spu_req(spu_req), .presence_edge(presence_edge),
    .short_edge(short_edge), .spu_release(spu_release),
    .pu_on(pu_on), .spu_done(spu_done)
  );

  // {pd, thr, apu, spu, pres, short, rel, exp_pu, exp_done}
  localparam logic [8:0] VEC [NV] = '{
    9'b1_0_1_0_0_0_0_0_0, // 0  pulldown starts
    9'b0_0_1_0_0_0_0_0_0, // 1  pulldown ends R2
    9'b0_0_1_0_0_0_0_0_0, // 2  rising, below threshold
    9'b0_1_1_0_0_0_0_1_0, // 3  R3 threshold -> on
    9'b0_1_1_0_0_0_0_1_0, // 4  R4
    9'b0_0_1_0_0_0_0_1_0, // 5  R4 third cycle
    9'b0_0_1_0_0_0_0_0_0, // 6  R4 expiry
    9'b1_0_1_0_0_0_0_0_0, // 7
    9'b0_0_1_0_0_0_0_0_0, // 8
    9'b0_1_1_1_0_0_0_1_0, // 9  R6 boost with strong request
    9'b0_0_1_1_0_0_0_1_0, // 10
    9'b0_0_1_1_0_0_0_1_0, // 11
    9'b0_0_1_1_0_0_0_1_0, // 12 R6 held past on-time
    9'b0_0_1_0_0_0_0_1_0, // 13 R6 still held
    9'b0_0_1_0_0_0_1_0_1, // 14 R7 release -> done pulse
    9'b0_0_1_0_0_0_0_0_0, // 15 R7 pulse one cycle
    9'b0_0_1_0_0_0_1_0_0, // 16 R10 release while idle
    9'b1_0_1_0_0_0_0_0_0, // 17
    9'b0_0_1_0_1_0_0_0_0, // 18 R5 presence edge
    9'b0_1_1_0_0_0_0_0_0, // 19 R5
    9'b0_1_1_0_0_0_0_0_0, // 20 R5
    9'b1_0_1_0_0_0_0_0_0, // 21
    9'b0_0_1_0_0_1_0_0_0, // 22 R5 short recovery
    9'b0_1_1_0_0_0_0_0_0, // 23 R5
    9'b1_0_0_0_0_0_0_0_0, // 24 R1 apu off
    9'b0_0_0_0_0_0_0_0_0, // 25 R1
    9'b0_1_0_0_0_0_0_0_0, // 26 R1
    9'b1_1_1_0_0_0_0_0_0, // 27 R2 threshold during pulldown
    9'b1_1_1_0_0_0_0_0_0, // 28 R2
    9'b0_1_1_0_0_0_0_0_0, // 29 R2 pulldown end only arms
    9'b0_1_1_0_0_0_0_1_0, // 30 R3
    9'b1_0_1_0_0_0_0_0_0, // 31 R8 pulldown cuts boost
    9'b0_0_1_0_0_0_0_0_0, // 32 R8 waits for threshold again
    9'b0_1_1_0_0_0_0_1_0, // 33
    9'b0_0_1_1_0_0_0_1_0, // 34
    9'b0_0_1_1_0_0_0_1_0, // 35
    9'b0_0_1_1_0_0_0_1_0, // 36 R6 hold
    9'b1_0_1_0_0_0_0_0_0, // 37 R8 pulldown cuts hold, no done
    9'b0_0_1_0_0_0_1_0_0, // 38 R10 release outside hold
    9'b0_0_1_0_0_0_0_0_0  // 39
  };

  task automatic check(input string req, input logic a_pu, input logic a_dn,
                       input logic e_pu, input logic e_dn);
    n_chk++;
    if (a_pu !== e_pu || a_dn !== e_dn) begin
      n_fail++;
      $display("FAIL %s: pu_on/spu_done = %b/%b, expected %b/%b",
               req, a_pu, a_dn, e_pu, e_dn);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R9 reset", pu_on, spu_done, 1'b0, 1'b0);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pd_active, thr_hit, apu_en, spu_req, presence_edge, short_edge, spu_release} = VEC[i][8:2];
      @(posedge clk);
      #1 check($sformatf("vector %0d", i), pu_on, spu_done, VEC[i][1], VEC[i][0]);
    end
    // R9: reset in the middle of a boost
    @(negedge clk); {pd_active, thr_hit, apu_en, spu_req, presence_edge, short_edge, spu_release} = 7'b1010000;
    @(negedge clk); pd_active = 1'b0;
    @(negedge clk); thr_hit = 1'b1;
    @(posedge clk); #1 check("R3 before reset", pu_on, spu_done, 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 check("R9 reset in boost", pu_on, spu_done, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 check("R9 idle after reset", pu_on, spu_done, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (10000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finish_run();
  end
endmodule